// File: doc/BRIEF.md
# Iterative HIGHT Block Cipher with Chaining Modes

This block encrypts and decrypts 64-bit data blocks under a 128-bit key with the HIGHT lightweight cipher, one block at a time, on an iterative datapath that performs one cipher round per clock. The per-round subkeys and their round constants are generated on the fly from the key, so no subkey table is stored. Around the cipher core sits a chaining layer that offers four standard block-cipher modes: electronic codebook, cipher block chaining, output feedback and counter. The layer keeps the chaining value, which is the previous block or the counter, from one block to the next.

A host presents a block with a valid/ready handshake. The result appears on a registered output with a one-cycle valid strobe exactly 34 cycles after acceptance. The core is ready for the next block during the final cycle of the current one, so a steady stream completes one block every 34 cycles. A restart pulse, honoured only while no block is held, loads the initial vector or counter seed into the chaining register. Padding and message framing belong to the host.

Byte numbering: data byte `P[n]` is `in_data[8n+7:8n]`, and key byte `MK[n]` is `key[8n+7:8n]`. Whitening keys are `MK[12..15]` on input and `MK[0..3]` on output. The round constants come from a 7-bit LFSR seeded with 0x5A.

Top module: `hight_mode_engine`

## Requirements
- R1: In codebook mode with `encrypt`=1, `out_data` is the HIGHT encryption of `in_data` under `key`, using the byte numbering above.
- R2: In codebook mode with `encrypt`=0, `out_data` is the HIGHT decryption of `in_data`, so it returns the plaintext of a block encrypted under the same key.
- R3: `out_valid` is a one-cycle pulse raised 34 clock edges after the edge that accepts a block. `in_ready` is high again in the last cycle, so back-to-back blocks come out exactly 34 cycles apart.
- R4: Mode code 1 (block chaining) with `encrypt`=1 gives `out = E(in XOR chain)`, and the chain becomes `out`.
- R5: Mode code 1 with `encrypt`=0 gives `out = D(in) XOR chain`, and the chain becomes the received ciphertext `in`.
- R6: Mode code 2 (output feedback) gives `out = E(chain) XOR in`, and the chain becomes `E(chain)`. The `encrypt` input has no effect.
- R7: Mode code 3 (counter) gives `out = E(chain) XOR in`, and the chain then increments by one modulo 2^64, wrapping from all-ones to zero. The `encrypt` input has no effect.
- R8: A `restart` pulse while no block is held loads `iv` into the chain and holds `in_ready` low in that cycle. A `restart` while a block is in flight is ignored.
- R9: After reset, `in_ready`=1, `out_valid`=0 and the chain value is zero.
- R10: Mode code 0 (codebook) gives `out = E(in)` or `D(in)` with no chain. `mode` and `encrypt` are captured when the block is accepted, and later changes do not affect that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| key | input | 128 | Cipher key, held stable while a block is in flight |
| iv | input | 64 | Initial vector or counter seed loaded on restart |
| mode | input | 2 | 0 codebook, 1 block chaining, 2 output feedback, 3 counter |
| encrypt | input | 1 | 1 encrypt, 0 decrypt (codebook and block chaining only) |
| restart | input | 1 | Load `iv` into the chain register when idle |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_data | input | 64 | Input block |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_data | output | 64 | Result block |

## Verification
The hardest situation to reach from the ports is the overlap at the end of a block. There, the next block is accepted on the same edge that the chaining register and the output are updated from the previous block. A block-chaining decrypt must also use the old ciphertext, not the one just captured. The stimulus drives `in_valid` at every falling edge on which `in_ready` is high, which lands each new block in the last cycle of the one before it in every mode. A further sequence asserts `restart` and toggles `mode` and `encrypt` while a block is in flight, to show that none of them disturbs the stream.

// File: rtl/hight_pkg.sv
package hight_pkg;

  localparam int BLK_W   = 64;
  localparam int KEY_W   = 128;
  localparam int ROUNDS  = 32;
  localparam int SK_PER  = 4;
  localparam int RND_W   = $clog2(ROUNDS);
  localparam int LATENCY = ROUNDS + 2;
  localparam int AGE_W   = $clog2(LATENCY) + 1;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    MODE_ECB = 2'd0,
    MODE_CBC = 2'd1,
    MODE_OFB = 2'd2,
    MODE_CTR = 2'd3
  } mode_e;

  localparam logic [6:0] DELTA_SEED = 7'h5A;

  // rotate-left mixes: 1,2,7 and 3,4,6
  function automatic byte_t f0(input byte_t x);
    return {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[0], x[7:1]};
  endfunction

  function automatic byte_t f1(input byte_t x);
    return {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]} ^ {x[1:0], x[7:2]};
  endfunction

  // one step of the x^7 + x^3 + 1 constant generator and its inverse
  function automatic logic [6:0] lfsr_fwd(input logic [6:0] d);
    return {d[3] ^ d[0], d[6:1]};
  endfunction

  function automatic logic [6:0] lfsr_bwd(input logic [6:0] d);
    return {d[5:0], d[6] ^ d[2]};
  endfunction

  function automatic logic [6:0] lfsr_fwd_n(input logic [6:0] d, input int n);
    logic [6:0] r;
    r = d;
    for (int i = 0; i < n; i++) r = lfsr_fwd(r);
    return r;
  endfunction

  function automatic logic [6:0] lfsr_bwd_n(input logic [6:0] d, input int n);
    logic [6:0] r;
    r = d;
    for (int i = 0; i < n; i++) r = lfsr_bwd(r);
    return r;
  endfunction

  // period is 127, so the constant of the last round group sits 3 steps behind the seed
  localparam logic [6:0] DELTA_LAST = lfsr_bwd_n(DELTA_SEED, 127 - (ROUNDS - 1) * SK_PER);

endpackage

// File: rtl/hight_keysched.sv
module hight_keysched
  import hight_pkg::*;
(
  input  logic [KEY_W-1:0]       key,
  input  logic [RND_W-1:0]       rnd_idx,
  input  logic [6:0]             delta,
  output logic [SK_PER*8-1:0]    sk
);

  for (genvar m = 0; m < SK_PER; m++) begin : g_sk
    logic [3:0] pos;
    logic [2:0] lo;
    logic [3:0] sel;
    byte_t      mkb;
    logic [6:0] dm;

    assign pos = {rnd_idx[1:0], 2'(m)};
    assign lo  = pos[2:0] - rnd_idx[RND_W-1:2];
    assign sel = {pos[3], lo};
    assign mkb = key[{sel, 3'b000} +: 8];

    if (m == 0) begin : g_d0
      assign dm = delta;
    end else begin : g_dn
      assign dm = lfsr_fwd_n(delta, m);
    end

    assign sk[8*m +: 8] = mkb + {1'b0, dm};
  end

endmodule

// File: rtl/hight_round.sv
module hight_round
  import hight_pkg::*;
(
  input  logic                  enc,
  input  logic [BLK_W-1:0]      x_in,
  input  logic [SK_PER*8-1:0]   sk,
  output logic [BLK_W-1:0]      x_out
);

  byte_t b [8];
  byte_t k0, k1, k2, k3;
  byte_t e0, e2, e4, e6;
  byte_t d1, d3, d5, d7;

  for (genvar j = 0; j < 8; j++) begin : g_split
    assign b[j] = x_in[8*j +: 8];
  end

  assign k0 = sk[7:0];
  assign k1 = sk[15:8];
  assign k2 = sk[23:16];
  assign k3 = sk[31:24];

  // forward round, output already rotated one byte position
  assign e0 = b[7] ^ (f0(b[6]) + k3);
  assign e2 = b[1] + (f1(b[0]) ^ k0);
  assign e4 = b[3] ^ (f0(b[2]) + k1);
  assign e6 = b[5] + (f1(b[4]) ^ k2);

  // inverse round, undoing the rotation
  assign d7 = b[0] ^ (f0(b[7]) + k3);
  assign d1 = b[2] - (f1(b[1]) ^ k0);
  assign d3 = b[4] ^ (f0(b[3]) + k1);
  assign d5 = b[6] - (f1(b[5]) ^ k2);

  assign x_out = enc ? {b[6], e6, b[4], e4, b[2], e2, b[0], e0}
                     : {d7, b[7], d5, b[5], d3, b[3], d1, b[1]};

endmodule

// File: rtl/hight_core.sv
module hight_core
  import hight_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              enc,
  input  logic [BLK_W-1:0]  din,
  input  logic [KEY_W-1:0]  key,
  output logic              idle,
  output logic              fin,
  output logic [BLK_W-1:0]  dout
);

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_FIN} phase_e;

  phase_e              phase_q, phase_d;
  logic [RND_W-1:0]    rnd_q, rnd_d;
  logic [BLK_W-1:0]    x_q, x_d;
  logic [6:0]          delta_q, delta_d;
  logic                enc_q, enc_d;
  logic                x_en;

  logic [RND_W-1:0]    rnd_idx;
  logic [SK_PER*8-1:0] sk;
  logic [BLK_W-1:0]    rnd_out;
  byte_t               wk [8];
  byte_t               di [8];
  byte_t               xs [8];
  logic [BLK_W-1:0]    pre_enc, pre_dec_y, pre_dec, post_enc_y, post_enc, post_dec;

  for (genvar i = 0; i < 4; i++) begin : g_wk
    assign wk[i]   = key[8*(i+12) +: 8];
    assign wk[i+4] = key[8*i +: 8];
  end

  for (genvar j = 0; j < 8; j++) begin : g_bytes
    assign di[j] = din[8*j +: 8];
    assign xs[j] = x_q[8*j +: 8];
  end

  // input whitening
  assign pre_enc   = {di[7], di[6] ^ wk[3], di[5], di[4] + wk[2],
                      di[3], di[2] ^ wk[1], di[1], di[0] + wk[0]};
  assign pre_dec_y = {di[7], di[6] ^ wk[7], di[5], di[4] - wk[6],
                      di[3], di[2] ^ wk[5], di[1], di[0] - wk[4]};
  assign pre_dec   = {pre_dec_y[55:0], pre_dec_y[63:56]};

  // output whitening
  assign post_enc_y = {x_q[7:0], x_q[63:8]};
  assign post_enc   = {post_enc_y[63:56], post_enc_y[55:48] ^ wk[7],
                       post_enc_y[47:40], post_enc_y[39:32] + wk[6],
                       post_enc_y[31:24], post_enc_y[23:16] ^ wk[5],
                       post_enc_y[15:8],  post_enc_y[7:0]   + wk[4]};
  assign post_dec   = {xs[7], xs[6] ^ wk[3], xs[5], xs[4] - wk[2],
                       xs[3], xs[2] ^ wk[1], xs[1], xs[0] - wk[0]};

  assign rnd_idx = enc_q ? rnd_q : ~rnd_q;

  hight_keysched u_ks (
    .key     (key),
    .rnd_idx (rnd_idx),
    .delta   (delta_q),
    .sk      (sk)
  );

  hight_round u_rnd (
    .enc   (enc_q),
    .x_in  (x_q),
    .sk    (sk),
    .x_out (rnd_out)
  );

  always_comb begin
    phase_d = phase_q;
    rnd_d   = rnd_q;
    x_d     = x_q;
    delta_d = delta_q;
    enc_d   = enc_q;
    x_en    = 1'b0;
    unique case (phase_q)
      C_IDLE: begin
        if (start) begin
          phase_d = C_RUN;
          rnd_d   = '0;
          enc_d   = enc;
          x_d     = enc ? pre_enc : pre_dec;
          delta_d = enc ? DELTA_SEED : DELTA_LAST;
          x_en    = 1'b1;
        end
      end
      C_RUN: begin
        x_d     = rnd_out;
        delta_d = enc_q ? lfsr_fwd_n(delta_q, SK_PER) : lfsr_bwd_n(delta_q, SK_PER);
        rnd_d   = rnd_q + 1'b1;
        x_en    = 1'b1;
        if (rnd_q == RND_W'(ROUNDS - 1)) phase_d = C_FIN;
      end
      default: phase_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= C_IDLE;
      rnd_q   <= '0;
      x_q     <= '0;
      delta_q <= '0;
      enc_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (x_en) begin
        rnd_q   <= rnd_d;
        x_q     <= x_d;
        delta_q <= delta_d;
        enc_q   <= enc_d;
      end
    end
  end

  assign idle = (phase_q == C_IDLE);
  assign fin  = (phase_q == C_FIN);
  assign dout = enc_q ? post_enc : post_dec;

  // R3: the chaining layer only starts the core when it is free
  a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == C_IDLE))
    else $error("core started while busy");

  // R3: the last round is always followed by the output cycle
  a_r3_fin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == C_RUN && rnd_q == RND_W'(ROUNDS - 1)) |=> fin)
    else $error("output cycle missing after last round");

endmodule

// File: rtl/hight_mode_engine.sv
module hight_mode_engine
  import hight_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key,
  input  logic [BLK_W-1:0]  iv,
  input  logic [1:0]        mode,
  input  logic              encrypt,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_data
);

  logic [1:0]        rsync_q;
  logic              rst_i_n;

  logic              load_q, load_d;
  logic [BLK_W-1:0]  data_q, data_d;
  mode_e             mode_q, mode_d;
  logic              dir_q, dir_d;
  logic [BLK_W-1:0]  chain_q, chain_d;
  logic              ov_q;
  logic [BLK_W-1:0]  od_q, od_d;
  logic [AGE_W-1:0]  age_q;

  logic              core_idle, core_fin, core_enc;
  logic [BLK_W-1:0]  core_din, core_res;
  logic              idle_all, accept, take_restart;
  logic [BLK_W-1:0]  out_fin, chain_fin;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign idle_all     = !load_q && core_idle;
  assign in_ready     = (idle_all && !restart) || core_fin;
  assign accept       = in_valid && in_ready;
  assign take_restart = restart && idle_all;

  always_comb begin
    unique case (mode_q)
      MODE_ECB: core_din = data_q;
      MODE_CBC: core_din = dir_q ? (data_q ^ chain_q) : data_q;
      default:  core_din = chain_q;
    endcase
    core_enc = (mode_q == MODE_ECB || mode_q == MODE_CBC) ? dir_q : 1'b1;
  end

  hight_core u_core (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (load_q),
    .enc   (core_enc),
    .din   (core_din),
    .key   (key),
    .idle  (core_idle),
    .fin   (core_fin),
    .dout  (core_res)
  );

  always_comb begin
    out_fin   = core_res;
    chain_fin = chain_q;
    unique case (mode_q)
      MODE_ECB: ;
      MODE_CBC: begin
        if (dir_q) begin
          chain_fin = core_res;
        end else begin
          out_fin   = core_res ^ chain_q;
          chain_fin = data_q;
        end
      end
      MODE_OFB: begin
        out_fin   = core_res ^ data_q;
        chain_fin = core_res;
      end
      default: begin
        out_fin   = core_res ^ data_q;
        chain_fin = chain_q + 1'b1;
      end
    endcase
  end

  always_comb begin
    load_d  = accept;
    data_d  = data_q;
    mode_d  = mode_q;
    dir_d   = dir_q;
    chain_d = chain_q;
    od_d    = od_q;
    if (accept) begin
      data_d = in_data;
      mode_d = mode_e'(mode);
      dir_d  = encrypt;
    end
    if (core_fin) begin
      chain_d = chain_fin;
      od_d    = out_fin;
    end else if (take_restart) begin
      chain_d = iv;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      load_q  <= 1'b0;
      data_q  <= '0;
      mode_q  <= MODE_ECB;
      dir_q   <= 1'b0;
      chain_q <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      load_q  <= load_d;
      ov_q    <= core_fin;
      if (accept) begin
        data_q <= data_d;
        mode_q <= mode_d;
        dir_q  <= dir_d;
      end
      if (core_fin || take_restart) chain_q <= chain_d;
      if (core_fin) od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // cycles since acceptance, kept for the latency check
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                                      age_q <= '0;
    else if (accept)                                   age_q <= AGE_W'(1);
    else if (age_q != '0 && age_q != {AGE_W{1'b1}})    age_q <= age_q + 1'b1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_i_n)
    core_fin |-> (age_q == AGE_W'(LATENCY)))
    else $error("result not ready at the fixed latency");

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |=> !out_valid)
    else $error("out_valid longer than one cycle");

  a_r3_no_accept_loading: assert property (@(posedge clk) disable iff (!rst_i_n)
    load_q |-> !in_ready)
    else $error("ready while a block is being loaded");

  a_r8_restart_in_flight: assert property (@(posedge clk) disable iff (!rst_i_n)
    (restart && !idle_all && !core_fin) |=> (chain_q == $past(chain_q)))
    else $error("restart disturbed chain during a block");

  a_r10_ctrl_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!core_idle && !core_fin) |=> ($stable(mode_q) && $stable(dir_q)))
    else $error("captured mode changed mid-block");

endmodule

// File: tb/hight_mode_engine_tb.sv
module hight_mode_engine_tb;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [127:0]  key_in;
  logic [63:0]   iv_in;
  logic [1:0]    mode_sel;
  logic          enc_sel;
  logic          restart;
  logic          in_valid;
  logic          in_ready;
  logic [63:0]   in_data;
  logic          out_valid;
  logic [63:0]   out_data;

  int cyc = 0;
  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] sin  [8];
  logic [63:0] sout [8];
  int          sacc [8];
  int          sobs [8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hight_mode_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key       (key_in),
    .iv        (iv_in),
    .mode      (mode_sel),
    .encrypt   (enc_sel),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // ---------------- independent cipher model ----------------
  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    logic [15:0] w;
    w = {x, x} << n;
    return w[15:8];
  endfunction

  function automatic logic [7:0] mf0(input logic [7:0] x);
    return rl(x, 1) ^ rl(x, 2) ^ rl(x, 7);
  endfunction

  function automatic logic [7:0] mf1(input logic [7:0] x);
    return rl(x, 3) ^ rl(x, 4) ^ rl(x, 6);
  endfunction

  function automatic logic [63:0] model_enc(input logic [127:0] k, input logic [63:0] p);
    logic [7:0] mk [16];
    logic [7:0] wk [8];
    logic [7:0] sk [128];
    logic       s  [134];
    logic [7:0] x  [8];
    logic [7:0] nx [8];
    logic [7:0] dl;
    logic [63:0] c;
    for (int i = 0; i < 16; i++) mk[i] = k[8*i +: 8];
    for (int i = 0; i < 4; i++) begin
      wk[i]   = mk[i+12];
      wk[i+4] = mk[i];
    end
    for (int i = 0; i < 7; i++) s[i] = (8'h5A >> i) & 1;
    for (int i = 7; i < 134; i++) s[i] = s[i-4] ^ s[i-7];
    for (int a = 0; a < 8; a++) begin
      for (int j = 0; j < 16; j++) begin
        dl = 8'h00;
        for (int b = 0; b < 7; b++) dl[b] = s[16*a + j + b];
        if (j < 8) sk[16*a+j] = mk[(j - a + 8) % 8] + dl;
        else       sk[16*a+j] = mk[(j - 8 - a + 8) % 8 + 8] + dl;
      end
    end
    for (int i = 0; i < 8; i++) x[i] = p[8*i +: 8];
    x[0] = x[0] + wk[0];
    x[2] = x[2] ^ wk[1];
    x[4] = x[4] + wk[2];
    x[6] = x[6] ^ wk[3];
    for (int r = 0; r < 32; r++) begin
      if (r < 31) begin
        nx[1] = x[0]; nx[3] = x[2]; nx[5] = x[4]; nx[7] = x[6];
        nx[0] = x[7] ^ (mf0(x[6]) + sk[4*r+3]);
        nx[2] = x[1] + (mf1(x[0]) ^ sk[4*r]);
        nx[4] = x[3] ^ (mf0(x[2]) + sk[4*r+1]);
        nx[6] = x[5] + (mf1(x[4]) ^ sk[4*r+2]);
      end else begin
        nx[0] = x[0]; nx[2] = x[2]; nx[4] = x[4]; nx[6] = x[6];
        nx[1] = x[1] + (mf1(x[0]) ^ sk[4*r]);
        nx[3] = x[3] ^ (mf0(x[2]) + sk[4*r+1]);
        nx[5] = x[5] + (mf1(x[4]) ^ sk[4*r+2]);
        nx[7] = x[7] ^ (mf0(x[6]) + sk[4*r+3]);
      end
      for (int i = 0; i < 8; i++) x[i] = nx[i];
    end
    x[0] = x[0] + wk[4];
    x[2] = x[2] ^ wk[5];
    x[4] = x[4] + wk[6];
    x[6] = x[6] ^ wk[7];
    for (int i = 0; i < 8; i++) c[8*i +: 8] = x[i];
    return c;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic print_summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // drive sin[0..n-1] as fast as in_ready allows, collect results
  task automatic run_stream(input int n, input logic [1:0] m, input logic d,
                            input bit scramble, input bit rs_mid, input logic [63:0] rs_iv);
    int got;
    got = 0;
    fork
      begin
        int k;
        bit rs_pend;
        k = 0;
        rs_pend = 1'b0;
        while (got < n) begin
          @(negedge clk);
          restart = 1'b0;
          if (rs_pend) begin
            restart = 1'b1;
            iv_in   = rs_iv;
            rs_pend = 1'b0;
          end
          if (k < n && in_ready) begin
            in_valid = 1'b1;
            in_data  = sin[k];
            mode_sel = m;
            enc_sel  = d;
            sacc[k]  = cyc + 1;
            if (rs_mid && k == 0) rs_pend = 1'b1;
            k++;
          end else begin
            in_valid = 1'b0;
            if (scramble) begin
              mode_sel = mode_sel + 2'd1;
              enc_sel  = ~enc_sel;
            end
          end
        end
        in_valid = 1'b0;
        restart  = 1'b0;
        mode_sel = m;
        enc_sel  = d;
      end
      begin
        while (got < n) begin
          @(negedge clk);
          if (out_valid) begin
            sout[got] = out_data;
            sobs[got] = cyc;
            got++;
          end
        end
      end
    join
  endtask

  task automatic restart_to(input logic [63:0] v);
    @(negedge clk);
    iv_in   = v;
    restart = 1'b1;
    in_valid = 1'b1;
    #1;
    check_int("R8 in_ready low during idle restart", int'(in_ready), 0);
    @(negedge clk);
    restart  = 1'b0;
    in_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  localparam logic [127:0] KEY_A = 128'hffeeddccbbaa99887766554433221100;
  localparam logic [127:0] KEY_B = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

  task automatic t_reset();
    @(negedge clk);
    check_int("R9 in_ready after reset", int'(in_ready), 1);
    check_int("R9 out_valid after reset", int'(out_valid), 0);
    key_in = KEY_A;
    sin[0] = 64'h1234_5678_9abc_def0;
    run_stream(1, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0);
    check64("R9 chain zero after reset", sout[0], model_enc(KEY_A, 64'h0) ^ sin[0]);
  endtask

  task automatic t_ecb_enc();
    key_in = KEY_A;
    sin[0] = 64'h0;
    sin[1] = 64'hffff_ffff_ffff_ffff;
    sin[2] = 64'h0123_4567_89ab_cdef;
    run_stream(3, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0);
    for (int i = 0; i < 3; i++) check64("R1 ecb encrypt", sout[i], model_enc(KEY_A, sin[i]));
    check64("R10 ecb has no chain", sout[0] ^ sout[1] ^ sout[2],
            model_enc(KEY_A, sin[0]) ^ model_enc(KEY_A, sin[1]) ^ model_enc(KEY_A, sin[2]));
  endtask

  task automatic t_ecb_dec();
    logic [63:0] pt [3];
    key_in = KEY_B;
    pt[0] = 64'hdead_beef_cafe_f00d;
    pt[1] = 64'h8000_0000_0000_0001;
    pt[2] = 64'h55aa_55aa_55aa_55aa;
    for (int i = 0; i < 3; i++) sin[i] = model_enc(KEY_B, pt[i]);
    run_stream(3, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0);
    for (int i = 0; i < 3; i++) check64("R2 ecb decrypt", sout[i], pt[i]);
  endtask

  task automatic t_stream();
    key_in = KEY_A;
    for (int i = 0; i < 4; i++) sin[i] = 64'h1111_0000_0000_0000 * (i + 1) + 64'(i);
    run_stream(4, 2'd0, 1'b1, 1'b0, 1'b0, 64'h0);
    for (int i = 0; i < 4; i++) check_int("R3 accept to out_valid", sobs[i] - sacc[i], 34);
    for (int i = 0; i < 3; i++) check_int("R3 back-to-back spacing", sobs[i+1] - sobs[i], 34);
    check64("R3 streamed data", sout[3], model_enc(KEY_A, sin[3]));
  endtask

  task automatic t_cbc();
    logic [63:0] pt [3];
    logic [63:0] ct [3];
    logic [63:0] ch;
    key_in = KEY_B;
    pt[0] = 64'h0000_0000_0000_0000;
    pt[1] = 64'h0000_0000_0000_0000;
    pt[2] = 64'h7777_6666_5555_4444;
    ch = 64'h0102_0304_0506_0708;
    for (int i = 0; i < 3; i++) begin
      ct[i] = model_enc(KEY_B, pt[i] ^ ch);
      ch = ct[i];
    end
    restart_to(64'h0102_0304_0506_0708);
    for (int i = 0; i < 3; i++) sin[i] = pt[i];
    run_stream(3, 2'd1, 1'b1, 1'b0, 1'b0, 64'h0);
    for (int i = 0; i < 3; i++) check64("R4 cbc encrypt", sout[i], ct[i]);
    restart_to(64'h0102_0304_0506_0708);
    for (int i = 0; i < 3; i++) sin[i] = ct[i];
    run_stream(3, 2'd1, 1'b0, 1'b0, 1'b0, 64'h0);
    for (int i = 0; i < 3; i++) check64("R5 cbc decrypt", sout[i], pt[i]);
  endtask

  task automatic t_ofb();
    logic [63:0] ks;
    key_in = KEY_A;
    restart_to(64'hfeed_face_0bad_f00d);
    sin[0] = 64'h0;
    sin[1] = 64'h1357_9bdf_2468_ace0;
    sin[2] = 64'hffff_0000_ffff_0000;
    run_stream(3, 2'd2, 1'b0, 1'b0, 1'b0, 64'h0);
    ks = 64'hfeed_face_0bad_f00d;
    for (int i = 0; i < 3; i++) begin
      ks = model_enc(KEY_A, ks);
      check64("R6 ofb with encrypt=0", sout[i], ks ^ sin[i]);
    end
  endtask

  task automatic t_ctr();
    logic [63:0] ctr;
    key_in = KEY_B;
    restart_to(64'hffff_ffff_ffff_fffe);
    for (int i = 0; i < 3; i++) sin[i] = 64'h0a0b_0c0d_0e0f_1011 + 64'(i);
    run_stream(3, 2'd3, 1'b1, 1'b0, 1'b0, 64'h0);
    ctr = 64'hffff_ffff_ffff_fffe;
    for (int i = 0; i < 3; i++) begin
      check64("R7 ctr keystream and wrap", sout[i], model_enc(KEY_B, ctr) ^ sin[i]);
      ctr = ctr + 64'd1;
    end
  endtask

  task automatic t_restart();
    key_in = KEY_A;
    restart_to(64'h0000_0000_0000_0100);
    sin[0] = 64'h5;
    sin[1] = 64'h6;
    run_stream(2, 2'd3, 1'b1, 1'b0, 1'b1, 64'h9999_9999_9999_9999);
    check64("R8 first block before ignored restart", sout[0], model_enc(KEY_A, 64'h100) ^ 64'h5);
    check64("R8 restart in flight ignored", sout[1], model_enc(KEY_A, 64'h101) ^ 64'h6);
    restart_to(64'h9999_9999_9999_9999);
    sin[0] = 64'h7;
    run_stream(1, 2'd3, 1'b1, 1'b0, 1'b0, 64'h0);
    check64("R8 idle restart loads iv", sout[0], model_enc(KEY_A, 64'h9999_9999_9999_9999) ^ 64'h7);
  endtask

  task automatic t_latch();
    key_in = KEY_B;
    sin[0] = 64'hc0ff_ee00_1234_0000;
    sin[1] = 64'h0000_4321_00ee_ffc0;
    run_stream(2, 2'd0, 1'b1, 1'b1, 1'b0, 64'h0);
    for (int i = 0; i < 2; i++) check64("R10 mode and direction captured", sout[i], model_enc(KEY_B, sin[i]));
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    print_summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    key_in   = '0;
    iv_in    = '0;
    mode_sel = 2'd0;
    enc_sel  = 1'b1;
    restart  = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ecb_enc();
    t_ecb_dec();
    t_stream();
    t_cbc();
    t_ofb();
    t_ctr();
    t_restart();
    t_latch();
    repeat (3) @(negedge clk);
    print_summary();
    $finish;
  end

endmodule